// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A controller pulses `cmd_start` with the start column and a read/write flag. Starting on the next cycle, the block gives one column address per clock until the burst ends. The programmed mode inputs set the burst length, the ordering and the write mode.

The two orderings are wrap-around counting and XOR (interleaved) ordering. Both stay inside the aligned block that the burst length defines. A full-page setting walks all 512 columns repeatedly until a stop request arrives. A single-write setting shortens every write to one beat, while reads keep the programmed length. A new command that arrives during a burst replaces it. The block holds no data path, no latency pipeline and no bank state.

Top module: `colgen_burst`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `col_valid` and `col_last` are low.
- R2: Length code 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. Beat 0 (the start column) appears on the cycle after the accepted `cmd_start`, and one beat follows per cycle after that.
- R3: With `cfg_interleave`=0, beat k carries the low bits ((start+k) mod L). The column bits above the L-sized block stay equal to those of the start column.
- R4: With `cfg_interleave`=1, beat k carries the low bits (start XOR k), and the upper bits are unchanged.
- R5: Length code 3'b111 with `cfg_interleave`=0 is full page. The address increments by one per cycle, wraps from 511 to 0, and never ends by itself. `col_last` is never high during a full-page burst.
- R6: Length codes 3'b100, 3'b101 and 3'b110 are reserved, and so is 3'b111 with `cfg_interleave`=1. A start pulse under any of these has no effect: no burst begins and a running burst continues.
- R7: With `cfg_single_wr`=1, a write (`cmd_write`=1) gives exactly one beat at the start column, whatever the length code. Reads still use the programmed length.
- R8: An accepted `cmd_start` during a running burst ends that burst. The new burst's beat 0 appears on the next cycle.
- R9: During a full-page burst, `cmd_stop` makes `col_valid` low from the next cycle on. For lengths 1, 2, 4 and 8, `cmd_stop` is ignored. When `cmd_start` and `cmd_stop` arrive together, the start wins.
- R10: `col_last` is high only on the final beat of a finite burst. If no new start is accepted, `col_valid` is low on the cycle after that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_code | input | 3 | Programmed burst length code |
| cfg_interleave | input | 1 | 1 selects XOR ordering, 0 selects wrap-around counting |
| cfg_single_wr | input | 1 | 1 makes every write a single beat |
| cmd_start | input | 1 | Read or write command pulse |
| cmd_write | input | 1 | 1 for write, 0 for read, sampled with `cmd_start` |
| cmd_col | input | 9 | Start column, sampled with `cmd_start` |
| cmd_stop | input | 1 | Burst stop request |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | 9 | Column address of the current beat |
| col_last | output | 1 | Current beat is the last of a finite burst |

## Verification
All results are registered once. Beat 0 follows an accepted start by exactly one cycle, and beat k follows it by k+1 cycles. A stop or a replacing start takes effect on the next cycle. The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge from those inputs, and the outputs are compared with the model on the following falling edge. This keeps every comparison at least one register after the stimulus that caused it.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    parameter int CW = 9;

    typedef logic [CW-1:0] col_t;

    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

    typedef struct packed {
        logic ok;
        logic page;
        logic xor_ord;
        col_t mask;
    } plan_t;

    function automatic plan_t plan_burst(input logic [2:0] code, input logic intl,
                                         input logic single, input logic wr);
        plan_t p;
        p.ok      = 1'b1;
        p.page    = 1'b0;
        p.xor_ord = intl;
        p.mask    = '0;
        case (code)
            LEN_ONE:   p.mask = col_t'(0);
            LEN_TWO:   p.mask = col_t'(1);
            LEN_FOUR:  p.mask = col_t'(3);
            LEN_EIGHT: p.mask = col_t'(7);
            LEN_PAGE: begin
                p.page = 1'b1;
                p.mask = '1;
                p.ok   = !intl;
            end
            default:   p.ok = 1'b0;
        endcase
        if (single && wr && p.ok) begin
            p.mask = '0;
            p.page = 1'b0;
        end
        return p;
    endfunction

    function automatic col_t form_addr(input col_t base, input col_t beat,
                                       input col_t mask, input logic xo);
        col_t low;
        if (xo) low = (base ^ beat) & mask;
        else    low = (base + beat) & mask;
        return (base & ~mask) | low;
    endfunction

endpackage

// File: rtl/colgen_plan.sv
module colgen_plan
    import colgen_pkg::*;
(
    input  logic [2:0] len_code,
    input  logic       intl,
    input  logic       single_wr,
    input  logic       start,
    input  logic       is_write,
    output plan_t      plan,
    output logic       go
);
    always_comb begin
        plan = plan_burst(len_code, intl, single_wr, is_write);
        go   = start && plan.ok;
    end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import colgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  plan_t plan,
    input  col_t  start_col,
    input  logic  stop,
    input  logic  last,
    output logic  active_q,
    output logic  page_q,
    output logic  xor_q,
    output col_t  mask_q,
    output col_t  base_q,
    output col_t  beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            page_q   <= 1'b0;
            xor_q    <= 1'b0;
            mask_q   <= '0;
            base_q   <= '0;
            beat_q   <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            page_q   <= plan.page;
            xor_q    <= plan.xor_ord;
            mask_q   <= plan.mask;
            base_q   <= start_col;
            beat_q   <= '0;
        end else if (active_q) begin
            if (page_q && stop)  active_q <= 1'b0;
            else if (last)       active_q <= 1'b0;
            else                 beat_q   <= beat_q + 1'b1;
        end
    end

    // R2
    start_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> (active_q && beat_q == '0));

    // R5
    page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && page_q) |-> !last);

    // R9
    page_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && page_q && stop && !go) |=> !active_q);

    // R10
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (last && !go) |=> !active_q);
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
    import colgen_pkg::*;
(
    input  logic active,
    input  logic page,
    input  logic xo,
    input  col_t mask,
    input  col_t base,
    input  col_t beat,
    output col_t addr,
    output logic last
);
    always_comb begin
        addr = form_addr(base, beat, mask, xo);
        last = active && !page && (beat == mask);
    end
endmodule

// File: rtl/colgen_burst.sv
module colgen_burst
    import colgen_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cfg_len_code,
    input  logic          cfg_interleave,
    input  logic          cfg_single_wr,
    input  logic          cmd_start,
    input  logic          cmd_write,
    input  logic [CW-1:0] cmd_col,
    input  logic          cmd_stop,
    output logic          col_valid,
    output logic [CW-1:0] col_addr,
    output logic          col_last
);
    plan_t plan;
    logic  go;
    logic  active_q, page_q, xor_q;
    col_t  mask_q, base_q, beat_q;
    col_t  addr;
    logic  last;

    colgen_plan u_plan (
        .len_code (cfg_len_code),
        .intl     (cfg_interleave),
        .single_wr(cfg_single_wr),
        .start    (cmd_start),
        .is_write (cmd_write),
        .plan     (plan),
        .go       (go)
    );

    colgen_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .plan     (plan),
        .start_col(cmd_col),
        .stop     (cmd_stop),
        .last     (last),
        .active_q (active_q),
        .page_q   (page_q),
        .xor_q    (xor_q),
        .mask_q   (mask_q),
        .base_q   (base_q),
        .beat_q   (beat_q)
    );

    colgen_addr u_addr (
        .active(active_q),
        .page  (page_q),
        .xo    (xor_q),
        .mask  (mask_q),
        .base  (base_q),
        .beat  (beat_q),
        .addr  (addr),
        .last  (last)
    );

    assign col_valid = active_q;
    assign col_addr  = addr;
    assign col_last  = last;

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> (!col_valid && !col_last));

    // R2
    first_col_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> (col_valid && col_addr == $past(cmd_col)));
endmodule

// File: tb/colgen_burst_test.sv
module colgen_burst_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_len_code = 3'b000;
    logic       cfg_interleave = 1'b0;
    logic       cfg_single_wr = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [8:0] cmd_col = '0;
    logic       cmd_stop = 1'b0;
    logic       col_valid;
    logic [8:0] col_addr;
    logic       col_last;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    int m_q[$];
    bit m_fp = 0;
    int m_fpaddr = 0;

    always #4 clk = ~clk;

    colgen_burst uut (
        .clk(clk), .rst(rst), .cfg_len_code(cfg_len_code),
        .cfg_interleave(cfg_interleave), .cfg_single_wr(cfg_single_wr),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .cmd_stop(cmd_stop), .col_valid(col_valid), .col_addr(col_addr),
        .col_last(col_last)
    );

    function automatic int beats_for(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 512;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_q.delete();
            m_fp = 0;
        end else begin
            int n;
            bit legal;
            n = beats_for(cfg_len_code);
            legal = (n != 0) && !(n == 512 && cfg_interleave);
            if (cmd_start && legal) begin
                m_q.delete();
                m_fp = 0;
                if (cfg_single_wr && cmd_write) n = 1;
                if (n == 512) begin
                    m_fp = 1;
                    m_fpaddr = int'(cmd_col);
                end else begin
                    int blk;
                    blk = (int'(cmd_col) / n) * n;
                    for (int k = 0; k < n; k++) begin
                        if (cfg_interleave) m_q.push_back(blk + ((int'(cmd_col) ^ k) % n));
                        else m_q.push_back(blk + ((int'(cmd_col) + k) % n));
                    end
                end
            end else if (m_fp) begin
                if (cmd_stop) m_fp = 0;
                else m_fpaddr = (m_fpaddr + 1) % 512;
            end else if (m_q.size() > 0) begin
                void'(m_q.pop_front());
            end
        end
    end

    task automatic compare();
        bit ev, el;
        int ea;
        ev = m_fp || (m_q.size() > 0);
        ea = m_fp ? m_fpaddr : ((m_q.size() > 0) ? m_q[0] : 0);
        el = !m_fp && (m_q.size() == 1);
        total++;
        if (col_valid !== ev) begin
            bad++;
            $display("FAIL %s valid actual=%b expected=%b", tag, col_valid, ev);
        end else if (ev && (int'(col_addr) != ea)) begin
            bad++;
            $display("FAIL %s addr actual=%0d expected=%0d", tag, col_addr, ea);
        end else if (col_last !== el) begin
            bad++;
            $display("FAIL %s last actual=%b expected=%b", tag, col_last, el);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            cmd_start = 1'b0;
            cmd_stop = 1'b0;
        end
    endtask

    task automatic issue(input logic [2:0] code, input logic intl, input logic wr,
                         input int col);
        @(negedge clk);
        compare();
        cmd_stop = 1'b0;
        cfg_len_code = code;
        cfg_interleave = intl;
        cmd_write = wr;
        cmd_col = 9'(col);
        cmd_start = 1'b1;
    endtask

    initial begin
        tag = "R1";
        tick(3);
        rst = 1'b0;
        tick(2);

        tag = "R2"; issue(3'd0, 0, 0, 37);  tick(4);
        tag = "R2"; issue(3'd1, 0, 0, 5);   tick(4);
        tag = "R2"; issue(3'd2, 0, 1, 6);   tick(6);
        tag = "R3"; issue(3'd3, 0, 0, 509); tick(10);
        tag = "R3"; issue(3'd2, 0, 0, 258); tick(6);
        tag = "R4"; issue(3'd3, 1, 0, 5);   tick(10);
        tag = "R4"; issue(3'd2, 1, 1, 302); tick(6);
        tag = "R5"; issue(3'd7, 0, 0, 508); tick(12);
        tag = "R9"; @(negedge clk); compare(); cmd_stop = 1'b1; tick(3);
        tag = "R6"; issue(3'd4, 0, 0, 10); tick(3);
        tag = "R6"; issue(3'd5, 0, 0, 10); tick(3);
        tag = "R6"; issue(3'd6, 1, 0, 10); tick(3);
        tag = "R6"; issue(3'd7, 1, 0, 10); tick(3);
        tag = "R6"; issue(3'd3, 0, 0, 40); tick(2);
        issue(3'd5, 0, 0, 99); tick(8);
        tag = "R7"; cfg_single_wr = 1'b1;
        issue(3'd3, 0, 1, 77); tick(4);
        issue(3'd7, 0, 1, 300); tick(4);
        issue(3'd3, 0, 0, 77); tick(10);
        cfg_single_wr = 1'b0;
        issue(3'd2, 0, 1, 77); tick(6);
        tag = "R8"; issue(3'd3, 0, 0, 16); tick(3);
        issue(3'd2, 1, 0, 129); tick(6);
        tag = "R8"; issue(3'd7, 0, 0, 510); tick(4);
        issue(3'd1, 0, 0, 3); tick(4);
        tag = "R9"; issue(3'd3, 0, 0, 200); tick(2);
        @(negedge clk); compare(); cmd_stop = 1'b1; tick(8);
        tag = "R9"; issue(3'd7, 0, 0, 100); tick(3);
        issue(3'd7, 0, 0, 400); cmd_stop = 1'b1; tick(5);
        @(negedge clk); compare(); cmd_stop = 1'b1; tick(3);
        tag = "R10"; issue(3'd1, 1, 0, 7); tick(1);
        issue(3'd0, 0, 0, 8); tick(4);
        tag = "R1"; rst = 1'b1; tick(2); rst = 1'b0; tick(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule